// File: doc/BRIEF.md
# NAND Flash Bus Cycle Timer

This block produces single bus cycles on the pins of an asynchronous NAND flash device. Each cycle is a command latch, an address latch, a data write or a data read. The host hands over one cycle at a time on a valid/ready request channel. The block then drives the latch-enable, write-strobe, read-strobe and data pins through three timed phases. Each phase length is a small programmable count of host clocks.

Every cycle runs as a setup phase, then a strobe phase, then a hold phase. During setup, the latch enable (for command and address cycles) and the outgoing data are already presented. During the strobe phase, the write or read strobe is held low. During the hold phase, the strobe is high again but the latch enable and the data stay where they were. When the hold phase ends, the block pulses a one-cycle response. For a read, that response carries the byte or halfword that was sampled on the last clock of the strobe phase.

Two further jobs are kept in this block:
- It watches the device's ready/busy pin through a synchronizer and records a chosen transition in a sticky flag.
- It records any request that arrives while the block is switched off.

Both flags can raise a shared interrupt line, each through its own enable. The request channel provides back-pressure only: `req_ready` is low from the cycle after a request is accepted until the block has returned to idle. The response pulse has no ready and cannot be stalled.

Top module: `nand_bus_timer`

## Requirements
- R1: After reset, the strobes are high, the latch enables are low, the data bus is not driven, `req_ready` is 1, and `rsp_valid`, both flags and `irq` are 0.
- R2: A request is accepted on a clock where `req_valid`, `req_ready` and `cfg_enable` are all 1. The setup phase that follows lasts `cfg_setup_len` clocks; a value of 0 skips it. Kind encoding is: 0 = command, 1 = address, 2 = write data, 3 = read data.
- R3: The strobe phase lasts `cfg_strobe_len`+1 clocks. During it, `nand_we_n` is low for kinds 0–2 and `nand_re_n` is low for kind 3. The two strobes are never low together.
- R4: The hold phase lasts `cfg_hold_len`+1 clocks. Throughout setup, strobe and hold:
  - `nand_cle` is high only for kind 0.
  - `nand_ale` is high only for kind 1.
  - For kinds 0–2, the request data is driven with `nand_dq_oe` = 1.
- R5: `req_ready` is 0 for exactly `cfg_setup_len`+`cfg_strobe_len`+`cfg_hold_len`+2 clocks after acceptance. In the next clock, `rsp_valid` is 1 for one clock only.
- R6: For a read, `nand_dq_oe` stays 0. `rsp_data` returns the `nand_dq_in` value sampled on the last clock of the strobe phase.
- R7: With `cfg_wide` = 0, the bus is 8 bits wide. Bits 15:8 are driven as 0 on writes and returned as 0 on reads. With `cfg_wide` = 1, all 16 bits are used.
- R8: `nand_ce_n[1:0]` follows `cfg_ce_n[1:0]` directly; a 0 selects the chip.
- R9: While `cfg_enable` = 0, a request is taken (`req_ready` = 1) and discarded. No strobe moves, no response pulse follows, and `bad_flag` sets one clock later.
- R10: `nand_rb` passes through a two-flop synchronizer. The edge selected by `cfg_rb_fall` (0 = low-to-high, 1 = high-to-low) sets `rb_flag` on the third clock edge after the pin changes. The other edge has no effect.
- R11: `rb_flag` and `bad_flag` stay set until a 1 on `rb_clr` or `bad_clr` clears them on the next clock. `irq` = (`rb_flag` & `cfg_rb_irq_en`) | (`bad_flag` & `cfg_bad_irq_en`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Controller on |
| cfg_setup_len | input | 3 | Setup phase length in clocks |
| cfg_strobe_len | input | 3 | Strobe phase length minus one |
| cfg_hold_len | input | 3 | Hold phase length minus one |
| cfg_wide | input | 1 | 0: 8-bit bus, 1: 16-bit bus |
| cfg_ce_n | input | 2 | Chip-enable pin levels |
| cfg_rb_fall | input | 1 | Ready/busy edge select |
| cfg_rb_irq_en | input | 1 | Ready/busy interrupt enable |
| cfg_bad_irq_en | input | 1 | Disabled-access interrupt enable |
| req_valid | input | 1 | Cycle request valid |
| req_ready | output | 1 | Block can accept a request |
| req_kind | input | 2 | Cycle kind |
| req_data | input | 16 | Command, address or write data |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_data | output | 16 | Read data |
| rb_clr | input | 1 | Clear ready/busy flag |
| bad_clr | input | 1 | Clear disabled-access flag |
| rb_flag | output | 1 | Sticky ready/busy edge flag |
| bad_flag | output | 1 | Sticky disabled-access flag |
| irq | output | 1 | Interrupt |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe |
| nand_re_n | output | 1 | Read strobe |
| nand_ce_n | output | 2 | Chip enables |
| nand_dq_out | output | 16 | Data bus out |
| nand_dq_oe | output | 1 | Data bus drive enable |
| nand_dq_in | input | 16 | Data bus in |
| nand_rb | input | 1 | Ready/busy pin |

## Verification
A bus cycle starts in the clock right after acceptance. Its pins then follow fixed counts: `cfg_setup_len` setup clocks, then strobe+1, then hold+1, with the response pulse in the next clock. The bench samples at the falling edge and counts busy, strobe and hold clocks against those sums. It drives the correct read value only on the last strobe clock and a wrong value elsewhere, so a capture on any other clock shows up as a wrong result. For the ready/busy flag, the bench checks that it is still clear two edges after the pin change and set after the third. Clears and disabled-access flags are checked one clock after their stimulus.

// File: rtl/nbt_pkg.sv
package nbt_pkg;
  typedef enum logic [1:0] {
    KIND_CMD   = 2'd0,
    KIND_ADDR  = 2'd1,
    KIND_WRITE = 2'd2,
    KIND_READ  = 2'd3
  } nbt_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } nbt_phase_e;
endpackage

// File: rtl/nbt_phase_seq.sv
module nbt_phase_seq
  import nbt_pkg::*;
#(
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [TW-1:0] setup_len_i,
  input  logic [TW-1:0] strobe_len_i,
  input  logic [TW-1:0] hold_len_i,
  output nbt_phase_e    phase_o,
  output logic          last_o,
  output logic          done_o
);
  nbt_phase_e    phase_q;
  logic [TW-1:0] cnt_q;
  logic [TW-1:0] strobe_q;
  logic [TW-1:0] hold_q;
  logic          done_q;

  assign phase_o = phase_q;
  assign last_o  = (cnt_q == '0);
  assign done_o  = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      strobe_q <= '0;
      hold_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            strobe_q <= strobe_len_i;
            hold_q   <= hold_len_i;
            if (setup_len_i != '0) begin
              phase_q <= PH_SETUP;
              cnt_q   <= setup_len_i - 1'b1;
            end else begin
              phase_q <= PH_STROBE;
              cnt_q   <= strobe_len_i;
            end
          end
        end
        PH_SETUP: begin
          if (cnt_q == '0) begin
            phase_q <= PH_STROBE;
            cnt_q   <= strobe_q;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_STROBE: begin
          if (cnt_q == '0) begin
            phase_q <= PH_HOLD;
            cnt_q   <= hold_q;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_HOLD: begin
          if (cnt_q == '0) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // R4: the last strobe clock always leads into the hold phase
  a_r4_strobe_then_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_STROBE && cnt_q == '0) |=> (phase_q == PH_HOLD));

  // R5: the completion pulse lasts a single clock
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R5: the completion pulse only ever follows a hold phase
  a_r5_done_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> ($past(phase_q) == PH_HOLD));
endmodule

// File: rtl/nbt_rb_watch.sv
module nbt_rb_watch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rb_i,
  input  logic fall_sel_i,
  input  logic clr_i,
  output logic flag_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   flag_q;
  logic                   rise_w;
  logic                   fall_w;
  logic                   hit_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], rb_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise_w = sync_q[SYNC_STAGES-1] & ~prev_q;
  assign fall_w = ~sync_q[SYNC_STAGES-1] & prev_q;
  assign hit_w  = fall_sel_i ? fall_w : rise_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (hit_w)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R11: the flag never drops without a clear request
  a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q);

  // R10: the flag only rises after the synchronized level has moved
  a_r10_rise_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> ($past(sync_q[SYNC_STAGES-1]) != $past(prev_q)));
endmodule

// File: rtl/nbt_pin_drive.sv
module nbt_pin_drive
  import nbt_pkg::*;
#(
  parameter int DW = 16
) (
  input  nbt_phase_e    phase_i,
  input  nbt_kind_e     kind_i,
  input  logic [DW-1:0] wdata_i,
  output logic          cle_o,
  output logic          ale_o,
  output logic          we_n_o,
  output logic          re_n_o,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o
);
  logic active_w;
  logic strobe_w;
  logic is_read_w;

  assign active_w  = (phase_i != PH_IDLE);
  assign strobe_w  = (phase_i == PH_STROBE);
  assign is_read_w = (kind_i == KIND_READ);

  always_comb begin
    cle_o   = active_w && (kind_i == KIND_CMD);
    ale_o   = active_w && (kind_i == KIND_ADDR);
    we_n_o  = !(strobe_w && !is_read_w);
    re_n_o  = !(strobe_w && is_read_w);
    dq_oe_o = active_w && !is_read_w;
    dq_o    = dq_oe_o ? wdata_i : '0;
  end
endmodule

// File: rtl/nand_bus_timer.sv
module nand_bus_timer
  import nbt_pkg::*;
#(
  parameter int DW = 16,
  parameter int TW = 3,
  parameter int CE_N = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_enable,
  input  logic [TW-1:0]   cfg_setup_len,
  input  logic [TW-1:0]   cfg_strobe_len,
  input  logic [TW-1:0]   cfg_hold_len,
  input  logic            cfg_wide,
  input  logic [CE_N-1:0] cfg_ce_n,
  input  logic            cfg_rb_fall,
  input  logic            cfg_rb_irq_en,
  input  logic            cfg_bad_irq_en,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [1:0]      req_kind,
  input  logic [DW-1:0]   req_data,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_data,
  input  logic            rb_clr,
  input  logic            bad_clr,
  output logic            rb_flag,
  output logic            bad_flag,
  output logic            irq,
  output logic            nand_cle,
  output logic            nand_ale,
  output logic            nand_we_n,
  output logic            nand_re_n,
  output logic [CE_N-1:0] nand_ce_n,
  output logic [DW-1:0]   nand_dq_out,
  output logic            nand_dq_oe,
  input  logic [DW-1:0]   nand_dq_in,
  input  logic            nand_rb
);
  localparam int NW = DW / 2;

  nbt_phase_e    phase_w;
  logic          last_w;
  logic          done_w;
  logic          start_w;
  logic          take_w;
  nbt_kind_e     kind_q;
  logic [DW-1:0] wdata_q;
  logic          wide_q;
  logic [DW-1:0] rdata_q;
  logic          bad_q;

  assign req_ready = (phase_w == PH_IDLE);
  assign take_w    = req_valid && req_ready;
  assign start_w   = take_w && cfg_enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= KIND_CMD;
      wdata_q <= '0;
      wide_q  <= 1'b0;
    end else if (start_w) begin
      kind_q  <= nbt_kind_e'(req_kind);
      wide_q  <= cfg_wide;
      wdata_q <= cfg_wide ? req_data : {{(DW-NW){1'b0}}, req_data[NW-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (phase_w == PH_STROBE && last_w && kind_q == KIND_READ) begin
      rdata_q <= wide_q ? nand_dq_in : {{(DW-NW){1'b0}}, nand_dq_in[NW-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       bad_q <= 1'b0;
    else if (take_w && !cfg_enable)   bad_q <= 1'b1;
    else if (bad_clr)                 bad_q <= 1'b0;
  end

  nbt_phase_seq #(.TW(TW)) seq_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_w),
    .setup_len_i  (cfg_setup_len),
    .strobe_len_i (cfg_strobe_len),
    .hold_len_i   (cfg_hold_len),
    .phase_o      (phase_w),
    .last_o       (last_w),
    .done_o       (done_w)
  );

  nbt_pin_drive #(.DW(DW)) pins_i (
    .phase_i (phase_w),
    .kind_i  (kind_q),
    .wdata_i (wdata_q),
    .cle_o   (nand_cle),
    .ale_o   (nand_ale),
    .we_n_o  (nand_we_n),
    .re_n_o  (nand_re_n),
    .dq_o    (nand_dq_out),
    .dq_oe_o (nand_dq_oe)
  );

  nbt_rb_watch #(.SYNC_STAGES(2)) rb_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rb_i       (nand_rb),
    .fall_sel_i (cfg_rb_fall),
    .clr_i      (rb_clr),
    .flag_o     (rb_flag)
  );

  assign nand_ce_n = cfg_ce_n;
  assign rsp_valid = done_w;
  assign rsp_data  = rdata_q;
  assign bad_flag  = bad_q;
  assign irq       = (rb_flag & cfg_rb_irq_en) | (bad_q & cfg_bad_irq_en);

  // R3: write and read strobes never low together
  a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  // R6: no drive on the data bus while the read strobe is low
  a_r6_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_dq_oe);

  // R9: a switched-off block stays idle
  a_r9_off_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_enable && req_ready) |=> req_ready);

  // R5: response arrives while ready is back high
  a_r5_rsp_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);

  // R4: latch enables are exclusive
  a_r4_latch_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));
endmodule

// File: tb/nand_bus_timer_tb_top.sv
module nand_bus_timer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b1;
  logic [2:0]  cfg_setup_len = 3'd1;
  logic [2:0]  cfg_strobe_len = 3'd1;
  logic [2:0]  cfg_hold_len = 3'd1;
  logic        cfg_wide = 1'b1;
  logic [1:0]  cfg_ce_n = 2'b11;
  logic        cfg_rb_fall = 1'b0;
  logic        cfg_rb_irq_en = 1'b0;
  logic        cfg_bad_irq_en = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = 2'd0;
  logic [15:0] req_data = 16'h0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic        rb_clr = 1'b0;
  logic        bad_clr = 1'b0;
  logic        rb_flag, bad_flag, irq;
  logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [1:0]  nand_ce_n;
  logic [15:0] nand_dq_out;
  logic [15:0] nand_dq_in = 16'h0;
  logic        nand_rb = 1'b1;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_bus_timer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
    .cfg_setup_len(cfg_setup_len), .cfg_strobe_len(cfg_strobe_len),
    .cfg_hold_len(cfg_hold_len), .cfg_wide(cfg_wide), .cfg_ce_n(cfg_ce_n),
    .cfg_rb_fall(cfg_rb_fall), .cfg_rb_irq_en(cfg_rb_irq_en),
    .cfg_bad_irq_en(cfg_bad_irq_en), .req_valid(req_valid),
    .req_ready(req_ready), .req_kind(req_kind), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rb_clr(rb_clr),
    .bad_clr(bad_clr), .rb_flag(rb_flag), .bad_flag(bad_flag), .irq(irq),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_ce_n(nand_ce_n), .nand_dq_out(nand_dq_out),
    .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic t_reset;
    check(nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dq_oe,
          "R1", "idle pins", {nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe}, 5'b11000);
    check(req_ready && !rsp_valid && !rb_flag && !bad_flag && !irq,
          "R1", "idle status", {req_ready, rsp_valid, rb_flag, bad_flag, irq}, 5'b10000);
  endtask

  // One bus cycle with full phase accounting
  task automatic t_cycle(input logic [1:0] k, input logic [15:0] d,
                         input int s, input int p, input int h,
                         input logic wide, input logic [15:0] rdv);
    int bus = 0, st_first = -1, st_cnt = 0;
    bit ctl_ok = 1'b1, dq_ok = 1'b1;
    logic [15:0] exp_w;
    logic [15:0] exp_r;
    exp_w = wide ? d : {8'h0, d[7:0]};
    exp_r = wide ? rdv : {8'h0, rdv[7:0]};
    cfg_setup_len = 3'(s); cfg_strobe_len = 3'(p); cfg_hold_len = 3'(h);
    cfg_wide = wide;
    @(negedge clk);
    req_kind = k; req_data = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; req_data = 16'hA5A5;
    while (!req_ready && bus < 40) begin
      if (k == 2'd3 ? !nand_re_n : !nand_we_n) begin
        if (st_first < 0) st_first = bus;
        st_cnt++;
      end
      if (nand_cle != (k == 2'd0) || nand_ale != (k == 2'd1)) ctl_ok = 1'b0;
      if (k == 2'd3) begin
        if (nand_dq_oe || !nand_we_n) dq_ok = 1'b0;
        nand_dq_in = (!nand_re_n && st_cnt == p + 1) ? rdv : ~rdv;
      end else begin
        if (!nand_dq_oe || nand_dq_out != exp_w || !nand_re_n) dq_ok = 1'b0;
      end
      bus++;
      @(negedge clk);
    end
    check(st_first == s, "R2", "setup clocks", st_first, s);
    check(st_cnt == p + 1, "R3", "strobe clocks", st_cnt, p + 1);
    check(bus - s - st_cnt == h + 1, "R4", "hold clocks", bus - s - st_cnt, h + 1);
    check(ctl_ok, "R4", "latch enables held", {nand_cle, nand_ale}, {k == 2'd0, k == 2'd1});
    check(dq_ok, k == 2'd3 ? "R6" : "R7", "data bus drive", nand_dq_out, exp_w);
    check(bus == s + p + h + 2, "R5", "busy clocks", bus, s + p + h + 2);
    check(rsp_valid, "R5", "response pulse", rsp_valid, 1);
    if (k == 2'd3)
      check(rsp_data == exp_r, wide ? "R6" : "R7", "read data", rsp_data, exp_r);
    @(negedge clk);
    check(!rsp_valid, "R5", "pulse one clock", rsp_valid, 0);
  endtask

  task automatic t_chip_enable;
    cfg_ce_n = 2'b10;
    @(negedge clk);
    check(nand_ce_n == 2'b10, "R8", "ce pins", nand_ce_n, 2'b10);
    cfg_ce_n = 2'b01;
    @(negedge clk);
    check(nand_ce_n == 2'b01, "R8", "ce pins", nand_ce_n, 2'b01);
    cfg_ce_n = 2'b11;
  endtask

  task automatic t_disabled;
    int strobes = 0;
    bit rsp_seen = 1'b0;
    cfg_enable = 1'b0; cfg_bad_irq_en = 1'b1;
    @(negedge clk);
    req_kind = 2'd2; req_data = 16'h1234; req_valid = 1'b1;
    check(req_ready, "R9", "request taken while off", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    check(bad_flag && irq, "R9", "bad flag and irq", {bad_flag, irq}, 2'b11);
    for (int i = 0; i < 12; i++) begin
      if (!nand_we_n || !nand_re_n) strobes++;
      if (rsp_valid) rsp_seen = 1'b1;
      @(negedge clk);
    end
    check(strobes == 0 && !rsp_seen, "R9", "no bus activity", {strobes[7:0], 7'b0, rsp_seen}, 0);
    cfg_bad_irq_en = 1'b0;
    #1;
    check(!irq, "R11", "irq gated off", irq, 0);
    bad_clr = 1'b1;
    @(negedge clk);
    bad_clr = 1'b0;
    check(!bad_flag, "R11", "bad flag cleared", bad_flag, 0);
    cfg_enable = 1'b1;
  endtask

  task automatic t_rb(input logic fall);
    cfg_rb_fall = fall; cfg_rb_irq_en = 1'b1;
    // ignored edge first
    nand_rb = fall;
    repeat (4) @(negedge clk);
    check(!rb_flag, "R10", "other edge ignored", rb_flag, 0);
    nand_rb = ~fall;
    repeat (2) @(negedge clk);
    check(!rb_flag, "R10", "not before third edge", rb_flag, 0);
    @(negedge clk);
    check(rb_flag && irq, "R10", "flag on third edge", {rb_flag, irq}, 2'b11);
    repeat (3) @(negedge clk);
    check(rb_flag, "R11", "flag sticky", rb_flag, 1);
    cfg_rb_irq_en = 1'b0;
    #1;
    check(!irq, "R11", "irq gated off", irq, 0);
    rb_clr = 1'b1;
    @(negedge clk);
    rb_clr = 1'b0;
    check(!rb_flag, "R11", "flag cleared", rb_flag, 0);
    nand_rb = 1'b1;
    repeat (4) @(negedge clk);
    rb_clr = 1'b1;
    @(negedge clk);
    rb_clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cycle(2'd0, 16'h0070, 2, 1, 0, 1'b0, 16'h0);
    t_cycle(2'd1, 16'h0155, 0, 0, 0, 1'b0, 16'h0);
    t_cycle(2'd2, 16'hBEEF, 7, 7, 7, 1'b1, 16'h0);
    t_cycle(2'd2, 16'hBEEF, 3, 2, 5, 1'b0, 16'h0);
    t_cycle(2'd3, 16'h0, 1, 3, 2, 1'b1, 16'hC35A);
    t_cycle(2'd3, 16'h0, 0, 0, 1, 1'b0, 16'h9E61);
    t_chip_enable();
    t_disabled();
    t_cycle(2'd0, 16'h0010, 1, 2, 1, 1'b0, 16'h0);
    t_rb(1'b0);
    t_rb(1'b1);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule